// File: doc/BRIEF.md
# Receive Frame Buffer with Consumer Handshake

This block sits between an Ethernet receive engine and a DMA-style consumer. The engine hands over frame bytes one at a time, beginning with the first destination-address byte, and marks the final byte of each frame. The block gives every stored byte a parity bit and keeps a running length of the frame in progress. When the address filter rejects a frame, or the engine reports a receive error, the bytes of that frame that are still held are thrown away and the rest of the frame is ignored. Bytes of frames that finished earlier are not touched.

On the read side the block offers the oldest held byte whenever it holds one. That byte comes out with its parity, an end-of-frame marker and a discard marker. The consumer pops bytes with a read enable. A frame that ends with a bad CRC keeps its bytes, and its final byte carries the discard marker. Sometimes a flush comes after the consumer has already taken part of a frame. In that case a single marker entry is queued so the consumer knows to drop what it took. A write that finds the 64-entry store full sets a sticky overflow flag and is handled as a receive error for that frame.

The write side is a three-state machine:
- State IDLE waits for the first byte of a frame.
- State RECV stores the bytes of a frame.
- State DROP discards bytes until the end of the frame.

Its transitions are:
- start (IDLE to RECV on a stored non-final byte).
- single (IDLE to IDLE on a stored final byte).
- finish (RECV to IDLE on a stored final byte).
- flush (IDLE or RECV to DROP on a reject, error or overflow with no final byte).
- flush_end (the same flush when it coincides with the final byte, which goes to IDLE).
- resume (DROP to IDLE on the final byte).

Top module: `rx_frame_fifo`

## Requirements
- R1: After reset the buffer is empty: rd_rdy is 0, frm_len is 0 and ovf_sticky is 0.
- R2: Each stored entry carries rd_par equal to the XOR of its 8 data bits (with the default even setting, the 9 bits together hold an even count of ones).
- R3: rd_rdy is 1 exactly while at least one entry is held, and bytes leave in the order they were stored; rd_en pops one entry per cycle while rd_rdy is 1.
- R4: rd_eof is 1 on the final byte of each frame and 0 on other bytes; rd_toss is 1 on that final byte when wr_crc_err was 1 with it.
- R5: frm_len counts the bytes stored into the current frame. It becomes 1 on the first byte, goes up by one per stored byte, and holds after the final byte until the next frame starts.
- R6: An addr_reject pulse during a frame removes that frame's unread bytes, leaves completed frames intact, clears frm_len to 0, and drops the remaining bytes up to and including the next final byte.
- R7: An rx_error pulse during a frame has the same flushing and dropping effect as R6; the frame after it is stored normally.
- R8: If the consumer already popped some bytes of the frame being flushed, exactly one marker entry is queued with data 0, rd_eof 1 and rd_toss 1.
- R9: A byte offered while 64 entries are held is not stored. It sets ovf_sticky, which stays 1 until reset, and flushes the current frame as in R6 and R8.
- R10: addr_reject and rx_error have no effect between frames or while a frame is being dropped.
- R11: A byte offered in the same cycle as addr_reject or rx_error during a frame is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A frame byte is offered this cycle |
| wr_data | input | 8 | Frame byte |
| wr_last | input | 1 | Offered byte is the final byte of the frame |
| wr_crc_err | input | 1 | Frame CRC failed; meaningful with wr_last |
| addr_reject | input | 1 | Address filter rejects the current frame |
| rx_error | input | 1 | Receive error in the current frame |
| rd_rdy | output | 1 | At least one entry is held |
| rd_en | input | 1 | Consumer pops the offered entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_par | output | 1 | Parity of the oldest entry |
| rd_eof | output | 1 | Oldest entry ends a frame |
| rd_toss | output | 1 | Consumer must discard the frame ending here |
| frm_len | output | 11 | Bytes stored into the current frame |
| ovf_sticky | output | 1 | A byte was lost to a full buffer since reset |

## Verification
The bench aims at flushes that hit a frame while an earlier completed frame is still queued. A design that rewinds the write pointer too far would lose or corrupt those older bytes. It also flushes a frame after the consumer has taken part of it, where a missing or duplicated marker entry shows up as a scoreboard mismatch. Further cases cover:
- a flush coinciding with an offered byte, which a wrong priority would store;
- reject and error pulses between frames and during a drop, which a careless state machine would act on;
- overflow at exactly 64 held entries, which an off-by-one full test would either store or miss.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_RECV = 2'd1,
        WS_DROP = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic       toss;
        logic       eof;
        logic       par;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  rx_entry_t       wentry,
    input  logic [AW-1:0]   raddr,
    output rx_entry_t       rentry
);

    rx_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wentry;
        end
    end

    assign rentry = mem[raddr];

endmodule

// File: rtl/rxf_rd_port.sv
module rxf_rd_port #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] rptr_nxt,
    output logic          rd_rdy
);

    logic fire;

    assign rd_rdy   = (wptr != rptr);
    assign fire     = rd_en && rd_rdy;
    assign rptr_nxt = fire ? rptr + PW'(1) : rptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
        end else begin
            rptr <= rptr_nxt;
        end
    end

endmodule

// File: rtl/rxf_wr_fsm.sv
module rxf_wr_fsm
    import rxf_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int CNT_W      = 11,
    parameter bit ODD_PARITY = 1'b0,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int MW = (CNT_W > PW) ? CNT_W : PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             wr_last,
    input  logic             wr_crc_err,
    input  logic             addr_reject,
    input  logic             rx_error,
    input  logic [PW-1:0]    rptr_nxt,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output rx_entry_t        wentry,
    output logic [PW-1:0]    wptr,
    output logic [CNT_W-1:0] frm_len,
    output logic             ovf_sticky,
    output wr_state_e        state
);

    wr_state_e        state_d;
    logic [PW-1:0]    wptr_d;
    logic [CNT_W-1:0] cnt_d;
    logic             ovf_d;

    logic [PW-1:0]    occ_after;
    logic             room;
    logic [CNT_W-1:0] cur;
    logic             flush_hit;
    logic             ovf_hit;
    logic             entered;
    logic [PW-1:0]    unread;
    logic [PW-1:0]    rewind;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= WS_IDLE;
            wptr       <= '0;
            frm_len    <= '0;
            ovf_sticky <= 1'b0;
        end else begin
            state      <= state_d;
            wptr       <= wptr_d;
            frm_len    <= cnt_d;
            ovf_sticky <= ovf_d;
        end
    end

    // flush bookkeeping derived from the post-read occupancy
    always_comb begin
        occ_after = wptr - rptr_nxt;
        room      = (occ_after < PW'(DEPTH));
        cur       = (state == WS_RECV) ? frm_len : '0;
        flush_hit = (state == WS_RECV) && (addr_reject || rx_error);
        ovf_hit   = wr_valid && !room && (state != WS_DROP) && !flush_hit;
        entered   = MW'(occ_after) < MW'(cur);
        unread    = entered ? occ_after : PW'(cur);
        rewind    = wptr - unread;
    end

    // next state and write port
    always_comb begin
        state_d     = state;
        wptr_d      = wptr;
        cnt_d       = frm_len;
        ovf_d       = ovf_sticky || ovf_hit;
        we          = 1'b0;
        waddr       = wptr[AW-1:0];
        wentry.data = wr_data;
        wentry.par  = (^wr_data) ^ ODD_PARITY;
        wentry.eof  = wr_last;
        wentry.toss = 1'b0;
        unique case (state)
            WS_IDLE, WS_RECV: begin
                if (flush_hit || ovf_hit) begin
                    cnt_d  = '0;
                    wptr_d = rewind;
                    if (entered) begin
                        we          = 1'b1;
                        waddr       = rewind[AW-1:0];
                        wentry.data = 8'h00;
                        wentry.par  = ODD_PARITY;
                        wentry.eof  = 1'b1;
                        wentry.toss = 1'b1;
                        wptr_d      = rewind + PW'(1);
                    end
                    state_d = (wr_valid && wr_last) ? WS_IDLE : WS_DROP;
                end else if (wr_valid) begin
                    we          = 1'b1;
                    wentry.toss = wr_last && wr_crc_err;
                    wptr_d      = wptr + PW'(1);
                    if (state == WS_IDLE) begin
                        cnt_d = CNT_W'(1);
                    end else if (frm_len != '1) begin
                        cnt_d = frm_len + CNT_W'(1);
                    end
                    state_d = wr_last ? WS_IDLE : WS_RECV;
                end
            end
            WS_DROP: begin
                if (wr_valid && wr_last) begin
                    state_d = WS_IDLE;
                end
            end
            default: state_d = WS_IDLE;
        endcase
    end

endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int CNT_W      = 11,
    parameter bit ODD_PARITY = 1'b0,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             wr_last,
    input  logic             wr_crc_err,
    input  logic             addr_reject,
    input  logic             rx_error,
    output logic             rd_rdy,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             rd_par,
    output logic             rd_eof,
    output logic             rd_toss,
    output logic [CNT_W-1:0] frm_len,
    output logic             ovf_sticky
);

    logic          we_w;
    logic [AW-1:0] waddr_w;
    rx_entry_t     wentry_w;
    rx_entry_t     rentry_w;
    logic [PW-1:0] wptr_w;
    logic [PW-1:0] rptr_w;
    logic [PW-1:0] rptr_nxt_w;
    wr_state_e     wst_w;

    rxf_wr_fsm #(
        .DEPTH      (DEPTH),
        .CNT_W      (CNT_W),
        .ODD_PARITY (ODD_PARITY)
    ) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .wr_last     (wr_last),
        .wr_crc_err  (wr_crc_err),
        .addr_reject (addr_reject),
        .rx_error    (rx_error),
        .rptr_nxt    (rptr_nxt_w),
        .we          (we_w),
        .waddr       (waddr_w),
        .wentry      (wentry_w),
        .wptr        (wptr_w),
        .frm_len     (frm_len),
        .ovf_sticky  (ovf_sticky),
        .state       (wst_w)
    );

    rxf_store #(
        .DEPTH (DEPTH)
    ) u_store (
        .clk    (clk),
        .we     (we_w),
        .waddr  (waddr_w),
        .wentry (wentry_w),
        .raddr  (rptr_w[AW-1:0]),
        .rentry (rentry_w)
    );

    rxf_rd_port #(
        .PW (PW)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .wptr     (wptr_w),
        .rptr     (rptr_w),
        .rptr_nxt (rptr_nxt_w),
        .rd_rdy   (rd_rdy)
    );

    assign rd_data = rentry_w.data;
    assign rd_par  = rentry_w.par;
    assign rd_eof  = rentry_w.eof;
    assign rd_toss = rentry_w.toss;

endmodule

// File: rtl/rx_frame_fifo_chk.sv
module rx_frame_fifo_chk
    import rxf_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int PW         = 7,
    parameter bit ODD_PARITY = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_rdy,
    input logic [7:0]    rd_data,
    input logic          rd_par,
    input logic          ovf_sticky,
    input logic          mem_we,
    input wr_state_e     wr_state,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr
);

    p_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rdy |-> ((^{rd_data, rd_par}) == ODD_PARITY));

    p_rdy_after_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> rd_rdy);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr - rptr) <= PW'(DEPTH));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky);

    p_drop_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state == WS_DROP) |-> !mem_we);

endmodule

bind rx_frame_fifo rx_frame_fifo_chk #(
    .DEPTH      (DEPTH),
    .PW         (PW),
    .ODD_PARITY (ODD_PARITY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_rdy     (rd_rdy),
    .rd_data    (rd_data),
    .rd_par     (rd_par),
    .ovf_sticky (ovf_sticky),
    .mem_we     (we_w),
    .wr_state   (wst_w),
    .wptr       (wptr_w),
    .rptr       (rptr_w)
);

// File: tb/rx_frame_fifo_tb.sv
module rx_frame_fifo_tb;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_last = 1'b0;
    logic        wr_crc_err = 1'b0;
    logic        addr_reject = 1'b0;
    logic        rx_error = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_rdy;
    logic [7:0]  rd_data;
    logic        rd_par;
    logic        rd_eof;
    logic        rd_toss;
    logic [10:0] frm_len;
    logic        ovf_sticky;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    // scoreboard model
    logic [10:0] q[$];   // {toss, eof, par, data}
    int mstate = 0;      // 0 idle, 1 in frame, 2 dropping
    int mcnt   = 0;
    int cur_in_q = 0;
    int cur_written = 0;
    bit movf = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    rx_frame_fifo u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .wr_last     (wr_last),
        .wr_crc_err  (wr_crc_err),
        .addr_reject (addr_reject),
        .rx_error    (rx_error),
        .rd_rdy      (rd_rdy),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .rd_par      (rd_par),
        .rd_eof      (rd_eof),
        .rd_toss     (rd_toss),
        .frm_len     (frm_len),
        .ovf_sticky  (ovf_sticky)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_flush(input bit last);
        for (int i = 0; i < cur_in_q; i++) void'(q.pop_back());
        if (cur_written > cur_in_q) q.push_back({1'b1, 1'b1, 1'b0, 8'h00});
        mcnt = 0;
        cur_in_q = 0;
        cur_written = 0;
        mstate = last ? 0 : 2;
    endtask

    // driver: one cycle with a byte offered, model updated
    task automatic wbyte(input logic [7:0] d, input bit last, input bit crc,
                         input bit rej, input bit err);
        bit flush;
        wr_valid = 1'b1; wr_data = d; wr_last = last; wr_crc_err = crc;
        addr_reject = rej; rx_error = err;
        flush = (mstate == 1) && (rej || err);
        if (mstate == 2) begin
            if (last) mstate = 0;
        end else if (flush) begin
            model_flush(last);
        end else if (q.size() >= DEPTH) begin
            movf = 1'b1;
            model_flush(last);
        end else begin
            if (mstate == 0) begin
                mcnt = 1; cur_in_q = 0; cur_written = 0;
            end else begin
                mcnt++;
            end
            q.push_back({last && crc, last, ^d, d});
            cur_in_q++; cur_written++;
            mstate = last ? 0 : 1;
            if (last) cur_in_q = 0;
        end
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0; wr_crc_err = 1'b0;
        addr_reject = 1'b0; rx_error = 1'b0;
        chk("R5 frame length", int'(frm_len), mcnt);
        chk("R9 overflow flag", int'(ovf_sticky), int'(movf));
    endtask

    // a flush pulse with no byte offered
    task automatic wflush(input bit rej, input bit err);
        addr_reject = rej; rx_error = err;
        if (mstate == 1) model_flush(1'b0);
        @(posedge clk); @(negedge clk);
        addr_reject = 1'b0; rx_error = 1'b0;
        chk("R10 frame length after pulse", int'(frm_len), mcnt);
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed, input bit crc);
        for (int i = 0; i < n; i++)
            wbyte(8'(seed + i * 7), i == n - 1, crc, 1'b0, 1'b0);
    endtask

    // monitor: pop one expected entry and compare with the design's output
    task automatic rd_check(input string req);
        logic [10:0] e;
        chk({req, " R3 ready"}, int'(rd_rdy), 1);
        if (q.size() == 0) begin
            chk({req, " R3 unexpected data"}, 1, 0);
        end else begin
            if (cur_in_q > 0 && q.size() == cur_in_q) cur_in_q--;
            e = q.pop_front();
            chk({req, " R3 data"}, int'(rd_data), int'(e[7:0]));
            chk({req, " R2 parity"}, int'(rd_par), int'(e[8]));
            chk({req, " R4 eof"}, int'(rd_eof), int'(e[9]));
            chk({req, " R4 toss"}, int'(rd_toss), int'(e[10]));
        end
        rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain(input string req);
        while (q.size() > 0) rd_check(req);
        chk({req, " R3 empty after drain"}, int'(rd_rdy), 0);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", int'(rd_rdy), 0);
        chk("R1 length", int'(frm_len), 0);
        chk("R1 overflow", int'(ovf_sticky), 0);

        // R2 R3 R4 R5: good frame then CRC-failed frame
        send_frame(5, 8'h11, 1'b0);
        send_frame(3, 8'hA5, 1'b1);
        drain("R4 crc frame");

        // R6 R11: reject mid-frame with a byte in the same cycle
        send_frame(4, 8'h30, 1'b0);
        wbyte(8'h41, 0, 0, 0, 0);
        wbyte(8'h42, 0, 0, 0, 0);
        wbyte(8'h43, 0, 0, 0, 0);
        wbyte(8'h44, 0, 0, 1, 0);
        chk("R6 length cleared", int'(frm_len), 0);
        wbyte(8'h45, 0, 0, 0, 0);
        wbyte(8'h46, 1, 0, 0, 0);
        send_frame(2, 8'h50, 1'b0);
        drain("R6 reject");

        // R7 R10: error pulse without a byte, pulses while dropping and idle
        send_frame(3, 8'h60, 1'b0);
        wbyte(8'h70, 0, 0, 0, 0);
        wbyte(8'h71, 0, 0, 0, 0);
        wflush(1'b0, 1'b1);
        wflush(1'b1, 1'b0);
        wbyte(8'h72, 0, 0, 1, 1);
        wbyte(8'h73, 1, 0, 0, 0);
        wflush(1'b1, 1'b1);
        send_frame(2, 8'h80, 1'b0);
        drain("R7 error");

        // R8: consumer took part of a frame before the flush
        wbyte(8'h90, 0, 0, 0, 0);
        wbyte(8'h91, 0, 0, 0, 0);
        wbyte(8'h92, 0, 0, 0, 0);
        wbyte(8'h93, 0, 0, 0, 0);
        rd_check("R8 partial");
        rd_check("R8 partial");
        wbyte(8'h94, 0, 0, 0, 1);
        wbyte(8'h95, 1, 0, 0, 0);
        drain("R8 marker");

        // R9: overflow on an empty buffer, whole frame lost
        for (int i = 0; i < 70; i++) wbyte(8'(i), i == 69, 0, 0, 0);
        chk("R9 empty after overflow", int'(rd_rdy), 0);
        send_frame(2, 8'hC0, 1'b0);
        drain("R9 after overflow");

        // R9: overflow keeps an earlier completed frame intact
        send_frame(60, 8'h05, 1'b0);
        send_frame(10, 8'hE0, 1'b0);
        drain("R9 earlier frame");
        chk("R9 sticky", int'(ovf_sticky), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule